// File: doc/BRIEF.md
# Audio Output Power Sequencer

This block decides when an audio output stage may drive its headphone and power-driver outputs. After a synchronous active-low reset and a clock-stable indication, it waits a fixed number of cycles in a low-power state and then brings the outputs up on its own. A soft ramp precedes full operation on the way up and follows it on the way down. Either ramp can be bypassed so that it takes no time.

Software can take control through a 4-bit write port. A write that sets the control-port enable bit hands control to the port. It cuts short any automatic start-up that is still waiting, puts the internal configuration back to defaults and emits a one-cycle defaults-load pulse for the surrounding register file. After that, a power-request bit in the configuration moves the stage up and down. The stand-alone ramp-up bypass comes from a pin until the port is enabled. From then on it comes from the register.

Top module: `amp_pwrseq`

## Requirements
- R1: When `rst_n` is sampled low, the next cycle shows `state_o` = 0 (reset hold), `hp_en`, `drv_en`, `ramp_busy` and `cp_sel` low, and the configuration at defaults (request 0, both bypasses 0).
- R2: The block leaves reset hold only on an edge where `rst_n` and `clk_ok` are both high, and it moves to low power (`state_o` = 1). While `clk_ok` is low it stays in reset hold.
- R3: Without a port-enable write, low power lasts exactly `SA_CYCLES` cycles. The block then enters ramp-up (`state_o` = 2).
- R4: Ramp-up lasts exactly `UP_CYCLES` cycles and is followed by active (`state_o` = 3). `hp_en` and `drv_en` are high only in ramp-up and active. `ramp_busy` is high only in ramp-up and ramp-down (`state_o` = 4).
- R5: With the up-bypass set, a power-up goes straight to active and skips ramp-up. The up-bypass is `pin_byp_up` while `cp_sel` is 0 and write bit 2 once `cp_sel` is 1.
- R6: A write with bit 0 set during the automatic low-power wait aborts that wait. The block stays in low power until a power request arrives. `cp_sel` is set. The other bits of that write are ignored and the configuration is reloaded with defaults.
- R7: `dflt_load` is high for exactly one cycle after each write with bit 0 set. It is also high for one cycle after the first edge with `rst_n` low taken from any state other than reset hold.
- R8: In port mode, a write that sets bit 1 (power request) while in low power or off (`state_o` = 5) starts power-up on the edge after the write.
- R9: In port mode, clearing bit 1 while active enters ramp-down on the next edge. Ramp-down lasts `DN_CYCLES` cycles and ends in off. With bit 3 (down-bypass) set, the block goes straight to off.
- R10: While `cp_sel` is 0, the power-request bit has no effect and active is held.
- R11: A port-enable write made while active in stand-alone mode sets `cp_sel` and reloads the defaults. The power request therefore reads 0, and ramp-down starts on the following edge.
- R12: `cp_sel` stays set across later writes with bit 0 clear, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_ok | input | 1 | Master and frame clocks are stable |
| wr_stb | input | 1 | One-cycle register write strobe |
| wr_data | input | 4 | Write data: bit 0 port enable, bit 1 power request, bit 2 up-bypass, bit 3 down-bypass |
| pin_byp_up | input | 1 | Stand-alone ramp-up bypass pin |
| hp_en | output | 1 | Headphone output enable |
| drv_en | output | 1 | Power-driver output enable |
| ramp_busy | output | 1 | A soft ramp is in progress |
| cp_sel | output | 1 | Shared pins belong to the control port |
| dflt_load | output | 1 | One-cycle request to reload register defaults |
| state_o | output | 3 | Sequencer state code |

## Verification
All outputs come from registers. Every output changes on the first edge that samples the cause: a reset or a write shows up one edge later, with `cp_sel` and `dflt_load` included. A configuration write acts on the state one edge after that, because the state machine reads the stored configuration. A timed phase entered at edge E ends at edge E plus its parameter. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from each stimulus to the exact edge on which a result is due. It checks the state both one edge before and on that edge, so any off-by-one in a counter is caught.

// File: rtl/amp_pwrseq_pkg.sv
// Package: shared state codes, write-field positions and configuration type
// for the audio output power sequencer. Assumes a 4-bit write port.
package amp_pwrseq_pkg;

    localparam int unsigned WR_W     = 4;
    localparam int unsigned F_CPEN   = 0;
    localparam int unsigned F_PWRUP  = 1;
    localparam int unsigned F_BYPUP  = 2;
    localparam int unsigned F_BYPDN  = 3;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_LOWPWR = 3'd1,
        ST_RAMPUP = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_RAMPDN = 3'd4,
        ST_OFF    = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic byp_dn;
        logic byp_up;
        logic pwrup;
    } seq_cfg_t;

    localparam seq_cfg_t CFG_DFLT = '{byp_dn: 1'b0, byp_up: 1'b0, pwrup: 1'b0};

endpackage

// File: rtl/amp_pwrseq_cfg.sv
// Module: configuration holder. Keeps the power request and both bypass bits,
// the sticky port-select flag, and raises the defaults-load pulse.
// Assumes wr_stb is one cycle per write; a port-enable write ignores its
// other data bits and restores the defaults instead.
module amp_pwrseq_cfg
    import amp_pwrseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [WR_W-1:0] wr_data,
    input  logic            in_hold,
    output seq_cfg_t        cfg,
    output logic            cp_sel,
    output logic            cp_wr,
    output logic            dflt_load
);

    seq_cfg_t cfg_q;
    logic     cp_q;
    logic     dflt_q;

    assign cp_wr = rst_n && wr_stb && wr_data[F_CPEN];

    // Purpose: store configuration fields and the sticky port-select flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_DFLT;
            cp_q  <= 1'b0;
        end else if (cp_wr) begin
            cfg_q <= CFG_DFLT;
            cp_q  <= 1'b1;
        end else if (wr_stb) begin
            cfg_q.pwrup  <= wr_data[F_PWRUP];
            cfg_q.byp_up <= wr_data[F_BYPUP];
            cfg_q.byp_dn <= wr_data[F_BYPDN];
        end
    end

    // Purpose: one-cycle defaults-load on reset entry or on a port-enable write.
    always_ff @(posedge clk) begin
        dflt_q <= rst_n ? cp_wr : !in_hold;
    end

    assign cfg       = cfg_q;
    assign cp_sel    = cp_q;
    assign dflt_load = dflt_q;

endmodule

// File: rtl/amp_pwrseq_timer.sv
// Module: phase timer. Counts cycles of the current timed phase and flags the
// last one. Assumes limit >= 1 and that clr is raised on every phase entry.
module amp_pwrseq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == (limit - CNT_W'(1)));

    // Purpose: advance the phase count, holding at the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/amp_pwrseq_fsm.sv
// Module: sequencing state machine. Walks reset hold, low power, ramps,
// active and off; owns the stand-alone wait flag and drives the phase timer.
// Assumes cfg and cp_sel are registered and cp_wr is the same-cycle write.
module amp_pwrseq_fsm
    import amp_pwrseq_pkg::*;
#(
    parameter int unsigned SA_CYCLES = 16,
    parameter int unsigned UP_CYCLES = 8,
    parameter int unsigned DN_CYCLES = 8,
    parameter int unsigned CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_ok,
    input  logic             cp_sel,
    input  logic             cp_wr,
    input  seq_cfg_t         cfg,
    input  logic             pin_byp_up,
    input  logic             tmr_done,
    output logic             tmr_clr,
    output logic             tmr_run,
    output logic [CNT_W-1:0] tmr_limit,
    output seq_state_e       state
);

    seq_state_e st_q, st_nxt;
    logic       sa_q, sa_nxt;
    logic       byp_up_eff;
    seq_state_e up_target;

    assign byp_up_eff = cp_sel ? cfg.byp_up : pin_byp_up;
    assign up_target  = byp_up_eff ? ST_ACTIVE : ST_RAMPUP;

    // Purpose: choose the next state and stand-alone wait flag.
    always_comb begin
        st_nxt = st_q;
        sa_nxt = sa_q;
        case (st_q)
            ST_HOLD: begin
                if (clk_ok) begin
                    st_nxt = ST_LOWPWR;
                    sa_nxt = !(cp_sel || cp_wr);
                end
            end
            ST_LOWPWR: begin
                if (sa_q) begin
                    if (cp_wr) begin
                        sa_nxt = 1'b0;
                    end else if (tmr_done) begin
                        st_nxt = up_target;
                        sa_nxt = 1'b0;
                    end
                end else if (cp_sel && cfg.pwrup) begin
                    st_nxt = up_target;
                end
            end
            ST_RAMPUP: begin
                if (tmr_done) st_nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cp_sel && !cfg.pwrup) st_nxt = cfg.byp_dn ? ST_OFF : ST_RAMPDN;
            end
            ST_RAMPDN: begin
                if (tmr_done) st_nxt = ST_OFF;
            end
            ST_OFF: begin
                if (cp_sel && cfg.pwrup) st_nxt = up_target;
            end
            default: begin
                st_nxt = ST_HOLD;
                sa_nxt = 1'b0;
            end
        endcase
    end

    // Purpose: select the length of the current timed phase.
    always_comb begin
        case (st_q)
            ST_LOWPWR: tmr_limit = CNT_W'(SA_CYCLES);
            ST_RAMPUP: tmr_limit = CNT_W'(UP_CYCLES);
            ST_RAMPDN: tmr_limit = CNT_W'(DN_CYCLES);
            default:   tmr_limit = CNT_W'(1);
        endcase
    end

    assign tmr_clr = (st_nxt != st_q) || cp_wr;
    assign tmr_run = (st_q == ST_LOWPWR && sa_q) || (st_q == ST_RAMPUP) || (st_q == ST_RAMPDN);

    // Purpose: hold the state and the stand-alone wait flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
            sa_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            sa_q <= sa_nxt;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/amp_pwrseq.sv
// Module: audio output power sequencer top. Ties together the configuration
// holder, the state machine and the phase timer, and decodes the enables.
// Assumes all phase lengths are at least one cycle.
module amp_pwrseq
    import amp_pwrseq_pkg::*;
#(
    parameter int unsigned SA_CYCLES = 2_625_000,
    parameter int unsigned UP_CYCLES = 625_000,
    parameter int unsigned DN_CYCLES = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_ok,
    input  logic       wr_stb,
    input  logic [3:0] wr_data,
    input  logic       pin_byp_up,
    output logic       hp_en,
    output logic       drv_en,
    output logic       ramp_busy,
    output logic       cp_sel,
    output logic       dflt_load,
    output logic [2:0] state_o
);

    localparam int unsigned MAX_AB  = (SA_CYCLES > UP_CYCLES) ? SA_CYCLES : UP_CYCLES;
    localparam int unsigned MAX_CYC = (MAX_AB > DN_CYCLES) ? MAX_AB : DN_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    seq_cfg_t         cfg;
    logic             cp_wr;
    logic             tmr_clr, tmr_run, tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    seq_state_e       st;

    amp_pwrseq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .in_hold   (st == ST_HOLD),
        .cfg       (cfg),
        .cp_sel    (cp_sel),
        .cp_wr     (cp_wr),
        .dflt_load (dflt_load)
    );

    amp_pwrseq_fsm #(
        .SA_CYCLES (SA_CYCLES),
        .UP_CYCLES (UP_CYCLES),
        .DN_CYCLES (DN_CYCLES),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_ok     (clk_ok),
        .cp_sel     (cp_sel),
        .cp_wr      (cp_wr),
        .cfg        (cfg),
        .pin_byp_up (pin_byp_up),
        .tmr_done   (tmr_done),
        .tmr_clr    (tmr_clr),
        .tmr_run    (tmr_run),
        .tmr_limit  (tmr_limit),
        .state      (st)
    );

    amp_pwrseq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    assign hp_en     = (st == ST_RAMPUP) || (st == ST_ACTIVE);
    assign drv_en    = (st == ST_RAMPUP) || (st == ST_ACTIVE);
    assign ramp_busy = (st == ST_RAMPUP) || (st == ST_RAMPDN);
    assign state_o   = st;

endmodule

// File: rtl/amp_pwrseq_chk.sv
// Module: temporal checks on the sequencer ports, attached by bind.
module amp_pwrseq_chk
    import amp_pwrseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clk_ok,
    input logic       wr_stb,
    input logic [3:0] wr_data,
    input logic       cp_sel,
    input logic       dflt_load,
    input logic [2:0] state_o
);

    logic en_wr;
    assign en_wr = wr_stb && wr_data[F_CPEN];

    a_r2_hold_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HOLD && !clk_ok) |=> (state_o == ST_HOLD));

    a_r4_rampup_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RAMPUP) |=> (state_o == ST_RAMPUP || state_o == ST_ACTIVE));

    a_r6_abort_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOWPWR && !cp_sel && en_wr) |=> (state_o == ST_LOWPWR));

    a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dflt_load && !en_wr) |=> !dflt_load);

    a_r9_rampdn_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RAMPDN) |=> (state_o == ST_RAMPDN || state_o == ST_OFF));

    a_r10_standalone_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && !cp_sel && !en_wr) |=> (state_o == ST_ACTIVE));

    a_r12_cp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cp_sel |=> cp_sel);

endmodule

bind amp_pwrseq amp_pwrseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_ok    (clk_ok),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .cp_sel    (cp_sel),
    .dflt_load (dflt_load),
    .state_o   (state_o)
);

// File: tb/amp_pwrseq_tb.sv
module amp_pwrseq_tb;
    import amp_pwrseq_pkg::*;

    localparam int unsigned SA = 20;
    localparam int unsigned UP = 8;
    localparam int unsigned DN = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ok = 1'b0;
    logic       wr_stb = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       pin_byp_up = 1'b0;
    logic       hp_en, drv_en, ramp_busy, cp_sel, dflt_load;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    amp_pwrseq #(.SA_CYCLES(SA), .UP_CYCLES(UP), .DN_CYCLES(DN)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .wr_stb(wr_stb),
        .wr_data(wr_data), .pin_byp_up(pin_byp_up), .hp_en(hp_en),
        .drv_en(drv_en), .ramp_busy(ramp_busy), .cp_sel(cp_sel),
        .dflt_load(dflt_load), .state_o(state_o)
    );

    // write data, gap in edges, expected state, enables, ramp flag
    typedef struct packed {
        logic [3:0] data;
        logic [7:0] gap;
        logic [2:0] st;
        logic       en;
        logic       rmp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'b0010, 8'd1,  3'd2, 1'b1, 1'b1},
        '{4'b0010, 8'd7,  3'd3, 1'b1, 1'b0},
        '{4'b0000, 8'd1,  3'd4, 1'b0, 1'b1},
        '{4'b0000, 8'd11, 3'd5, 1'b0, 1'b0},
        '{4'b0110, 8'd1,  3'd3, 1'b1, 1'b0},
        '{4'b1000, 8'd1,  3'd5, 1'b0, 1'b0},
        '{4'b0010, 8'd1,  3'd2, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [3:0] d);
        wr_stb  = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_stb  = 1'b0;
        wr_data = 4'd0;
    endtask

    task automatic outs(input string tag, input logic [2:0] st, input logic en, input logic rmp);
        check({tag, " state"}, 32'(state_o), 32'(st));
        check({tag, " hp_en"}, 32'(hp_en), 32'(en));
        check({tag, " drv_en"}, 32'(drv_en), 32'(en));
        check({tag, " ramp_busy"}, 32'(ramp_busy), 32'(rmp));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        tick(3);
        // R1 reset state
        outs("R1 reset", 3'd0, 1'b0, 1'b0);
        check("R1 cp_sel", 32'(cp_sel), 0);

        // R2 stays in hold without clk_ok
        rst_n = 1'b1;
        tick(5);
        check("R2 hold w/o clk_ok", 32'(state_o), 0);
        clk_ok = 1'b1;
        tick(1);
        check("R2 to low power", 32'(state_o), 1);

        // R3 stand-alone wait length, R4 ramp-up length
        tick(SA - 1);
        check("R3 still low power", 32'(state_o), 1);
        tick(1);
        outs("R3 ramp-up entry", 3'd2, 1'b1, 1'b1);
        tick(UP - 1);
        check("R4 still ramp-up", 32'(state_o), 2);
        tick(1);
        outs("R4 active", 3'd3, 1'b1, 1'b0);

        // R10 power request ignored in stand-alone mode
        write(4'b0000);
        tick(30);
        outs("R10 active held", 3'd3, 1'b1, 1'b0);
        check("R10 cp_sel", 32'(cp_sel), 0);

        // R11 and R7: port enable while active
        write(4'b0001);
        check("R11 cp_sel", 32'(cp_sel), 1);
        check("R7 pulse on write", 32'(dflt_load), 1);
        check("R11 active before", 32'(state_o), 3);
        tick(1);
        check("R7 pulse ends", 32'(dflt_load), 0);
        outs("R11 ramp-down", 3'd4, 1'b0, 1'b1);

        // R1 and R7: reset from ramp-down
        rst_n = 1'b0;
        tick(1);
        outs("R1 reset mid-ramp", 3'd0, 1'b0, 1'b0);
        check("R1 cp_sel cleared", 32'(cp_sel), 0);
        check("R7 pulse on reset", 32'(dflt_load), 1);
        tick(1);
        check("R7 reset pulse ends", 32'(dflt_load), 0);

        // R6 abort of stand-alone wait, other write bits ignored
        rst_n = 1'b1;
        tick(1);
        check("R6 low power", 32'(state_o), 1);
        tick(4);
        write(4'b0111);
        check("R6 cp_sel", 32'(cp_sel), 1);
        check("R7 pulse on abort", 32'(dflt_load), 1);
        tick(40);
        outs("R6 abort holds low power", 3'd1, 1'b0, 1'b0);

        // R8 R9 R5 R12 R4: table walk in port mode
        for (int i = 0; i < 7; i++) begin
            write(VECS[i].data);
            tick(int'(VECS[i].gap));
            outs($sformatf("R8/R9/R5 vec%0d", i), VECS[i].st, VECS[i].en, VECS[i].rmp);
            check($sformatf("R12 vec%0d cp_sel", i), 32'(cp_sel), 1);
        end

        // R5 pin bypass in stand-alone mode
        rst_n = 1'b0;
        tick(1);
        pin_byp_up = 1'b1;
        rst_n = 1'b1;
        tick(1);
        check("R5 low power", 32'(state_o), 1);
        tick(SA - 1);
        check("R5 still low power", 32'(state_o), 1);
        tick(1);
        outs("R5 straight to active", 3'd3, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule